// File: doc/BRIEF.md
# MDIO Management Command Controller

This block lets a host reach the management registers of an external Ethernet PHY over a two-wire MDC/MDIO link, using clause-22 read and write frames. The host sees one 32-bit command word. A single write to that word supplies the PHY address, the register address, the direction and, for writes, the 16-bit data. If the start flag is set, the same write launches the transaction. The host then polls the same word until the busy flag drops. After a read it finds the register value, or a failure flag if no PHY answered.

Internally a programmable divider derives MDC from the system clock. A shifter sends each frame MSB first: a 32-bit preamble of ones, start pattern `01`, opcode, both addresses, turnaround and 16 data bits. On reads the shifter releases MDIO from the turnaround onward and samples the PHY's answer. The command register accepts no update while a frame is in flight.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After synchronous active-low reset the command word reads 0, MDC is low, the MDIO output enable is low and the MDIO output is 1.
- R2: Command word layout: bit 29 start/busy, bit 28 read failure, bit 27 direction (1 = read, 0 = write), bits 25:21 PHY address, bits 20:16 register address, bits 15:0 data. Bits 31:30 and bit 26 always read 0. The failure flag is 0 whenever a transaction starts.
- R3: A write sends 64 MDC bits, MSB first: 32 ones, `01`, opcode `01`, PHY address, register address, turnaround `10`, then the 16 data bits. The output enable is high for all 64 bits.
- R4: A read sends the same first 46 bits, but with opcode `10`. The controller drives MDIO for those 46 bits and releases it (output enable low) for bits 46 to 63.
- R5: When a read completes and the PHY drove the second turnaround bit low, bits 15:0 hold the 16 bits the PHY returned, MSB first, and bit 28 is 0.
- R6: If MDIO is not low at the second turnaround bit of a read, bit 28 becomes 1 and bits 15:0 become 0 at completion. A write never sets bit 28.
- R7: A write to the command word while busy is set has no effect on any field or on the frame in progress.
- R8: Busy clears by itself when the last frame bit ends. While busy is clear, MDC stays low and MDIO is not driven.
- R9: MDIO output and output enable change only on MDC falling edges. Input data is sampled on MDC rising edges.
- R10: Each MDC high phase and low phase lasts max(`mdc_div`, 1) system clock cycles, so a frame holds MDC high for 64·max(`mdc_div`,1) cycles.
- R11: A write with bit 29 clear loads the address, direction and data fields, clears bit 28 and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word write value |
| cmd_rdata | output | 32 | Command/status word, readable at any time |
| mdc_div | input | 8 | MDC half period in system clocks (0 acts as 1) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The hardest case to reach from the ports is a read in which the PHY answers with valid data bits but fails to pull the second turnaround bit low. The controller must then raise the failure flag and discard data that looks valid. The bench's PHY responder can spoil only the turnaround bit while still driving the data field, so a design that merely checks the data would not pass. A second difficult case is a command written mid-frame: the bench issues it while the responder is part way through a write and then checks both the unchanged fields and the bits it captured from the line.

// File: rtl/mdio_pkg.sv
// Package: shared field positions, frame constants and the decoded
// command type for the MDIO management controller.
package mdio_pkg;

    localparam int CMD_W        = 32;
    localparam int BUSY_BIT     = 29;
    localparam int FAIL_BIT     = 28;
    localparam int READ_BIT     = 27;
    localparam int PHY_LSB      = 21;
    localparam int REG_LSB      = 16;
    localparam int ADDR_W       = 5;
    localparam int DATA_W       = 16;
    // bits after the preamble: start, op, two addresses, turnaround, data
    localparam int BODY_LEN     = 2 + 2 + 2 * ADDR_W + 2 + DATA_W;

    localparam logic [1:0] SOF_PAT  = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] TA_WRITE = 2'b10;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] data;
    } mdio_cmd_t;

endpackage

// File: rtl/mdio_clkgen.sv
// Module: MDC generator. While enabled, toggles MDC every max(half_cfg,1)
// system clocks and flags the cycle in which MDC is about to rise or fall.
// Assumes half_cfg is held steady while enabled; MDC rests low when idle.
module mdio_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half_cfg,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;
    logic             wrap;

    // Purpose: terminal count of one MDC phase (zero treated as one cycle).
    always_comb begin
        lim  = (half_cfg == '0) ? '0 : half_cfg - DIV_W'(1);
        wrap = en && (cnt == lim);
        rise_tick = wrap && !mdc;
        fall_tick = wrap && mdc;
    end

    // Purpose: phase counter and MDC toggle flop.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/mdio_shifter.sv
// Module: clause-22 frame shifter. On launch, builds the full frame and
// shifts it out MSB first, one bit per MDC period, changing the line on
// falling ticks and sampling MDIO on rising ticks. For reads it releases
// the line from the first turnaround bit, checks that the PHY pulls the
// second turnaround bit low, and collects 16 data bits.
// Assumes launch only arrives while inactive.
module mdio_shifter
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      launch,
    input  mdio_cmd_t cmd,
    input  logic      rise_tick,
    input  logic      fall_tick,
    input  logic      mdio_i,
    output logic      active,
    output logic      mdio_o,
    output logic      mdio_oe,
    output logic      done,
    output logic      rx_fail,
    output logic [DATA_W-1:0] rx_data
);
    localparam int FRAME_LEN = PRE_LEN + BODY_LEN;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam int TA_POS    = PRE_LEN + 4 + 2 * ADDR_W;
    localparam logic [IDX_W-1:0] LAST_IDX    = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] REL_IDX     = IDX_W'(TA_POS - 1);
    localparam logic [IDX_W-1:0] TA2_IDX     = IDX_W'(TA_POS + 1);
    localparam logic [IDX_W-1:0] DATA0_IDX   = IDX_W'(TA_POS + 2);

    logic [FRAME_LEN-1:0] sr;
    logic [FRAME_LEN-1:0] frame;
    logic [IDX_W-1:0]     idx;
    logic                 is_rd;
    logic                 oe_q;

    // Purpose: assemble the outgoing frame from the command fields.
    always_comb begin
        frame = {{PRE_LEN{1'b1}}, SOF_PAT,
                 cmd.rd ? OP_READ : OP_WRITE,
                 cmd.phy, cmd.regad,
                 cmd.rd ? 2'b11 : TA_WRITE,
                 cmd.rd ? {DATA_W{1'b1}} : cmd.data};
    end

    // Purpose: frame sequencing, line driving and read-back capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            idx     <= '0;
            sr      <= '1;
            oe_q    <= 1'b0;
            is_rd   <= 1'b0;
            done    <= 1'b0;
            rx_fail <= 1'b0;
            rx_data <= '0;
        end else begin
            done <= 1'b0;
            if (launch && !active) begin
                active  <= 1'b1;
                idx     <= '0;
                sr      <= frame;
                oe_q    <= 1'b1;
                is_rd   <= cmd.rd;
                rx_fail <= 1'b0;
                rx_data <= '0;
            end else if (active) begin
                if (rise_tick && is_rd) begin
                    if (idx == TA2_IDX && mdio_i != 1'b0) begin
                        rx_fail <= 1'b1;
                    end
                    if (idx >= DATA0_IDX) begin
                        rx_data <= {rx_data[DATA_W-2:0], mdio_i};
                    end
                end
                if (fall_tick) begin
                    if (idx == LAST_IDX) begin
                        active <= 1'b0;
                        oe_q   <= 1'b0;
                        sr     <= '1;
                        done   <= 1'b1;
                    end else begin
                        idx  <= idx + IDX_W'(1);
                        sr   <= {sr[FRAME_LEN-2:0], 1'b1};
                        oe_q <= !(is_rd && idx >= REL_IDX);
                    end
                end
            end
        end
    end

    // Purpose: idle line reads as released-high.
    always_comb begin
        mdio_oe = oe_q;
        mdio_o  = oe_q ? sr[FRAME_LEN-1] : 1'b1;
    end

endmodule

// File: rtl/mdio_cmdreg.sv
// Module: host command/status word. Loads fields when idle, raises busy
// and issues a one-cycle launch when the start bit is written, ignores
// writes while busy, and folds read results back at completion.
module mdio_cmdreg
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CMD_W-1:0]  wr_data,
    input  logic              done,
    input  logic              rx_fail,
    input  logic [DATA_W-1:0] rx_data,
    output mdio_cmd_t         cmd,
    output logic              launch,
    output logic [CMD_W-1:0]  status
);
    logic busy;
    logic fail;
    logic unused_wbits;

    assign unused_wbits = ^{wr_data[31:30], wr_data[FAIL_BIT], wr_data[26]};

    // Purpose: command fields, busy/fail flags and launch pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd    <= '0;
            busy   <= 1'b0;
            fail   <= 1'b0;
            launch <= 1'b0;
        end else begin
            launch <= 1'b0;
            if (done) begin
                busy <= 1'b0;
                if (cmd.rd) begin
                    fail     <= rx_fail;
                    cmd.data <= rx_fail ? '0 : rx_data;
                end
            end else if (wr_en && !busy) begin
                cmd.rd    <= wr_data[READ_BIT];
                cmd.phy   <= wr_data[PHY_LSB +: ADDR_W];
                cmd.regad <= wr_data[REG_LSB +: ADDR_W];
                cmd.data  <= wr_data[DATA_W-1:0];
                fail      <= 1'b0;
                busy      <= wr_data[BUSY_BIT];
                launch    <= wr_data[BUSY_BIT];
            end
        end
    end

    // Purpose: pack the readable status word.
    always_comb begin
        status                        = '0;
        status[BUSY_BIT]              = busy;
        status[FAIL_BIT]              = fail;
        status[READ_BIT]              = cmd.rd;
        status[PHY_LSB +: ADDR_W]     = cmd.phy;
        status[REG_LSB +: ADDR_W]     = cmd.regad;
        status[DATA_W-1:0]            = cmd.data;
    end

endmodule

// File: rtl/mdio_cmd_ctrl.sv
// Module: top of the MDIO management command controller. Ties the host
// command word, the MDC divider and the frame shifter together.
// Assumes mdc_div is not changed while a frame is in progress.
module mdio_cmd_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_wdata,
    output logic [CMD_W-1:0]  cmd_rdata,
    input  logic [DIV_W-1:0]  mdc_div,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    mdio_cmd_t         cmd;
    logic              launch;
    logic              active;
    logic              done;
    logic              rx_fail;
    logic [DATA_W-1:0] rx_data;
    logic              rise_tick;
    logic              fall_tick;

    mdio_cmdreg i_cmdreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cmd_wr),
        .wr_data (cmd_wdata),
        .done    (done),
        .rx_fail (rx_fail),
        .rx_data (rx_data),
        .cmd     (cmd),
        .launch  (launch),
        .status  (cmd_rdata)
    );

    mdio_clkgen #(.DIV_W(DIV_W)) i_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (active),
        .half_cfg  (mdc_div),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_shifter #(.PRE_LEN(PRE_LEN)) i_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .cmd       (cmd),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .active    (active),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .done      (done),
        .rx_fail   (rx_fail),
        .rx_data   (rx_data)
    );

endmodule

// File: rtl/mdio_cmd_ctrl_chk.sv
// Module: property checker for mdio_cmd_ctrl, attached by bind.
// Observes only the top-level ports.
module mdio_cmd_ctrl_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      cmd_rdata,
    input logic [DIV_W-1:0] mdc_div,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe
);
    logic [DIV_W:0] hi_len;
    logic [DIV_W:0] exp_len;

    // Purpose: length of the current MDC high phase in system clocks.
    always_ff @(posedge clk) begin
        if (!rst_n || !mdc) hi_len <= '0;
        else                hi_len <= hi_len + 1'b1;
    end

    assign exp_len = (mdc_div == '0) ? (DIV_W+1)'(1) : {1'b0, mdc_div};

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rdata[31:30] == 2'b00) && !cmd_rdata[26]);

    assert_launch_nofail_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_rdata[29]) |-> !cmd_rdata[28]);

    assert_write_nofail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_rdata[27] |-> !cmd_rdata[28]);

    assert_fields_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rdata[29] |=> $stable(cmd_rdata[27:16]));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_rdata[29] |-> (!mdc && !mdio_oe));

    assert_mdio_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> $fell(mdc));

    assert_release_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdio_oe) |-> $fell(mdc));

    assert_mdc_high_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdc) |-> (hi_len == exp_len));

endmodule

bind mdio_cmd_ctrl mdio_cmd_ctrl_chk #(.DIV_W(DIV_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_rdata (cmd_rdata),
    .mdc_div   (mdc_div),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/test_mdio_cmd_ctrl.sv
// Bench: vector table of management transactions against a PHY responder
// model, followed by directed reset and corner-case tests.
module test_mdio_cmd_ctrl;

    localparam logic [4:0] PHY_ADDR = 5'd1;
    localparam int NVEC = 10;
    // {div[3:0], rd, phy[4:0], reg[4:0], data[15:0]}
    localparam logic [30:0] VEC [NVEC] = '{
        {4'd2, 1'b0, 5'd1,  5'd3,  16'h1234},
        {4'd1, 1'b1, 5'd1,  5'd3,  16'h0000},
        {4'd0, 1'b0, 5'd1,  5'd31, 16'hFFFF},
        {4'd3, 1'b1, 5'd1,  5'd31, 16'h0000},
        {4'd5, 1'b1, 5'd1,  5'd0,  16'h0000},
        {4'd2, 1'b1, 5'd2,  5'd5,  16'h0000},
        {4'd1, 1'b0, 5'd1,  5'd0,  16'h0000},
        {4'd2, 1'b1, 5'd1,  5'd0,  16'h0000},
        {4'd4, 1'b0, 5'd31, 5'd16, 16'h8001},
        {4'd2, 1'b1, 5'd1,  5'd16, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic [7:0]  mdc_div = 8'd2;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [15:0] phy_regs [32];
    logic [63:0] cap_o;
    logic [63:0] cap_oe;
    int          pcnt = 0;
    logic        frame_rst = 1'b0;
    logic        bad_ta = 1'b0;
    logic        respond = 1'b0;
    logic [15:0] resp_val = '0;
    int          hi_cnt = 0;
    int          viol = 0;
    logic        prev_mdc = 1'b0;
    logic        prev_o = 1'b1;
    logic        prev_oe = 1'b0;

    always #5 clk = ~clk;

    mdio_cmd_ctrl i_mdio_cmd_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_wdata (cmd_wdata),
        .cmd_rdata (cmd_rdata),
        .mdc_div   (mdc_div),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    // PHY side: capture each bit on MDC rising edge (bit k lands in cap[63-k])
    always @(posedge mdc or posedge frame_rst) begin
        if (frame_rst) begin
            pcnt = 0;
        end else if (pcnt < 64) begin
            cap_o[63-pcnt]  = mdio_o;
            cap_oe[63-pcnt] = mdio_oe;
            pcnt = pcnt + 1;
        end
    end

    // PHY side: drive turnaround and data on MDC falling edge for reads
    always @(negedge mdc) begin
        if (pcnt == 47) begin
            respond  = (cap_o[29:28] == 2'b10) && (cap_o[27:23] == PHY_ADDR);
            resp_val = phy_regs[cap_o[22:18]];
            mdio_i   = (respond && !bad_ta) ? 1'b0 : 1'b1;
        end else if (pcnt >= 48 && pcnt <= 63) begin
            mdio_i = respond ? resp_val[63-pcnt] : 1'b1;
        end else begin
            mdio_i = 1'b1;
        end
    end

    // Line monitor: MDC high time and edge discipline (R9, R10)
    always @(negedge clk) begin
        if (frame_rst) hi_cnt = 0;
        else if (mdc) hi_cnt = hi_cnt + 1;
        if (rst_n) begin
            if (mdio_o !== prev_o && !(prev_mdc && !mdc)) viol = viol + 1;
            if (prev_oe && !mdio_oe && !(prev_mdc && !mdc)) viol = viol + 1;
        end
        prev_mdc = mdc;
        prev_o   = mdio_o;
        prev_oe  = mdio_oe;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [31:0] w);
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_wdata = w;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (cmd_rdata[29] && n < 20000) begin
            @(negedge clk);
            n = n + 1;
        end
        check("R8 busy clears", {63'd0, cmd_rdata[29]}, 64'd0);
    endtask

    function automatic logic [31:0] mkword(input logic go, input logic rd,
        input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
        return {2'b00, go, 1'b0, rd, 1'b0, phy, rg, d};
    endfunction

    task automatic run_cmd(input logic rd, input logic [4:0] phy,
        input logic [4:0] rg, input logic [15:0] d, input logic [7:0] dv);
        logic [63:0] exp_f;
        logic        exp_fail;
        logic [15:0] exp_d;
        int          h;
        mdc_div = dv;
        h = (dv == 0) ? 1 : int'(dv);
        exp_fail = rd && (phy != PHY_ADDR || bad_ta);
        exp_d = rd ? (exp_fail ? 16'h0000 : phy_regs[rg]) : d;
        exp_f = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg, 2'b10, d};
        @(negedge clk);
        frame_rst = 1'b1;
        @(negedge clk);
        frame_rst = 1'b0;
        write_word(mkword(1'b1, rd, phy, rg, d));
        check("R2 busy set after start", {63'd0, cmd_rdata[29]}, 64'd1);
        wait_idle();
        if (!rd) begin
            check("R3 write frame bits", cap_o, exp_f);
            check("R3 write drive enable", cap_oe, {64{1'b1}});
            if (phy == PHY_ADDR) phy_regs[rg] = cap_o[15:0];
        end else begin
            check("R4 read header bits", {18'd0, cap_o[63:18]}, {18'd0, exp_f[63:18]});
            check("R4 read release", cap_oe, {{46{1'b1}}, 18'd0});
        end
        check(rd ? (exp_fail ? "R6 status word" : "R5 status word") : "R2 status word",
              {32'd0, cmd_rdata}, {32'd0, mkword(1'b0, rd, phy, rg, exp_d) | {3'b000, exp_fail, 28'd0}});
        check("R10 MDC high cycles", 64'(hi_cnt), 64'(64 * h));
    endtask

    initial begin
        for (int r = 0; r < 32; r++) phy_regs[r] = 16'hA000 | 16'(r * 16'h0111);
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 word after reset", {32'd0, cmd_rdata}, 64'd0);
        check("R1 line idle after reset", {61'd0, mdc, mdio_oe, mdio_o}, 64'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            run_cmd(VEC[i][26], VEC[i][25:21], VEC[i][20:16], VEC[i][15:0], {4'd0, VEC[i][30:27]});
        end

        // R6: PHY spoils only the second turnaround bit but still returns data
        bad_ta = 1'b1;
        run_cmd(1'b1, PHY_ADDR, 5'd3, 16'h0000, 8'd2);
        bad_ta = 1'b0;
        run_cmd(1'b1, PHY_ADDR, 5'd3, 16'h0000, 8'd1);
        check("R6 fail cleared by good read", {63'd0, cmd_rdata[28]}, 64'd0);

        // R11: load without start
        @(negedge clk);
        frame_rst = 1'b1;
        @(negedge clk);
        frame_rst = 1'b0;
        write_word(mkword(1'b0, 1'b1, 5'd9, 5'd4, 16'hBEEF));
        repeat (200) @(negedge clk);
        check("R11 fields loaded, not busy", {32'd0, cmd_rdata}, {32'd0, mkword(1'b0, 1'b1, 5'd9, 5'd4, 16'hBEEF)});
        check("R11 no MDC activity", 64'(pcnt), 64'd0);

        // R7: command written mid-frame is ignored
        mdc_div = 8'd2;
        @(negedge clk);
        frame_rst = 1'b1;
        @(negedge clk);
        frame_rst = 1'b0;
        write_word(mkword(1'b1, 1'b0, PHY_ADDR, 5'd7, 16'h5555));
        repeat (40) @(negedge clk);
        write_word(mkword(1'b1, 1'b1, 5'd2, 5'd9, 16'h0F0F));
        check("R7 word unchanged while busy", {32'd0, cmd_rdata},
              {32'd0, mkword(1'b1, 1'b0, PHY_ADDR, 5'd7, 16'h5555)});
        wait_idle();
        check("R7 frame unchanged", cap_o,
              {32'hFFFF_FFFF, 2'b01, 2'b01, PHY_ADDR, 5'd7, 2'b10, 16'h5555});
        phy_regs[cap_o[22:18]] = cap_o[15:0];
        run_cmd(1'b1, PHY_ADDR, 5'd7, 16'h0000, 8'd1);
        check("R7 read back of written value", {48'd0, cmd_rdata[15:0]}, 64'h5555);

        check("R8 idle line after runs", {62'd0, mdc, mdio_oe}, 64'd0);
        check("R9 edge discipline violations", 64'(viol), 64'd0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule